// File: doc/BRIEF.md
# Multi-Source Reset Combiner with Pad Pulse Stretcher

This block merges every internal reset request of the chip with a debounced external reset pin and produces one synchronous system reset. The internal requests are power-on, the independent watchdog, the window watchdog (which also carries software reset), the debug-interface reset and the illegal-opcode trap. Any request, even one lasting a single sample-clock cycle, is registered on its leading edge. That edge starts a stretch counter. While the counter runs, the block enables an open-drain pull-down on the bidirectional reset pad, so that parts outside the chip see a guaranteed minimum low pulse. The block only ever enables the pull-down. The high level comes from the board pull-up.

The pad level comes back through `pad_in`, which must already be synchronized to `clk`. A saturating up/down counter filters it. The counter climbs by one per low sample. It falls by a larger step per high sample, so a burst of short negative spikes cannot build up into a detection. While the block pulls the pad low itself, and for a short settle window after that, the filter is held at zero. This stops the block's own pulse from retriggering it. All durations are parameters counted in sample-clock cycles.

Top module: `rst_hub`

## Requirements
- R1: While `rst` is high, `sys_rst` reads 1 and `pad_pull_en` reads 0. At the first edge after `rst` falls with no request pending, `sys_rst` goes to 0.
- R2: A one-cycle pulse on any of `por_req`, `iwdg_req`, `wwdg_req`, `dbg_req` or `illop_req` sets `pad_pull_en` to 1 right after the edge that samples it.
- R3: After a single leading edge of the combined request, `pad_pull_en` stays high for exactly `DRIVE_CYC` cycles.
- R4: A new leading edge of the combined request during a stretch reloads the full `DRIVE_CYC` length. The pull-down run then lasts the gap between the two edges plus `DRIVE_CYC`.
- R5: `sys_rst` is high whenever, at the previous edge, a request was active, the stretch or settle window (`DRIVE_CYC + SETTLE_CYC` cycles) was running, or an external low was detected. After a lone one-cycle request, `sys_rst` is high for `DRIVE_CYC + SETTLE_CYC + 1` cycles.
- R6: From idle, a low run on `pad_in` of fewer than `VALID_CYC` samples never raises `sys_rst`.
- R7: A low run of `L >= VALID_CYC` samples on `pad_in` holds `sys_rst` high for `L - VALID_CYC + 1` cycles, and it never enables `pad_pull_en`.
- R8: A train of low runs of at most `SPIKE_MAX` samples, each separated by at least one high sample, never raises `sys_rst`, however long it lasts.
- R9: `pad_in` is ignored while `pad_pull_en` is high and for `SETTLE_CYC` cycles after. An external low that lies wholly inside that window neither lengthens `sys_rst` nor starts a new pulse.
- R10: A request held high longer than the stretch does not extend `pad_pull_en` beyond `DRIVE_CYC`. `sys_rst` stays high for as long as the request lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_req | input | 1 | Power-on reset request |
| iwdg_req | input | 1 | Independent watchdog reset request |
| wwdg_req | input | 1 | Window watchdog or software reset request |
| dbg_req | input | 1 | Debug-interface reset request |
| illop_req | input | 1 | Illegal-opcode reset request |
| pad_in | input | 1 | Synchronized level of the reset pad |
| pad_pull_en | output | 1 | Open-drain pull-down enable for the pad |
| sys_rst | output | 1 | Synchronous system reset, active high |

## Verification
Several faults show up as wrong lengths of `sys_rst` or `pad_pull_en`:
- A stretch counter that loads or decrements wrongly shifts the fall of `pad_pull_en` within the same `DRIVE_CYC` window, and the fall of `sys_rst` a settle window later.
- A filter with the wrong down step lets a spike train raise `sys_rst` within a few dozen samples.
- A missing self-mask lets the block's own pulse raise `sys_rst` again once the pulse ends.

Every one of these is a change in the length of a high run, and it is visible within one stretch period. So the bench compares both outputs each cycle against a behavioural model, and it also measures the exact run lengths.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;

    typedef struct packed {
        logic por;
        logic iwdg;
        logic wwdg;
        logic dbg;
        logic illop;
    } rst_src_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DRIVE  = 2'd1,
        PH_SETTLE = 2'd2
    } drive_phase_e;

    function automatic logic any_source(input rst_src_t s);
        return s.por | s.iwdg | s.wwdg | s.dbg | s.illop;
    endfunction

endpackage

// File: rtl/rst_hub_merge.sv
module rst_hub_merge
    import rst_hub_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rst_src_t src,
    output logic     req_any,
    output logic     req_start
);
    logic req_q;

    assign req_any   = any_source(src);
    assign req_start = req_any & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_any;
    end
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch
    import rst_hub_pkg::*;
#(
    parameter int unsigned DRIVE_CYC  = 2500,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pull_en,
    output logic busy
);
    localparam int unsigned TOTAL = DRIVE_CYC + SETTLE_CYC;
    localparam int CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LOAD  = CW'(TOTAL);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt;
    drive_phase_e  phase;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start)         cnt <= LOAD;
        else if (cnt != '0)     cnt <= cnt - CW'(1);
    end

    always_comb begin
        if (cnt == '0)          phase = PH_IDLE;
        else if (cnt > LIMIT)   phase = PH_DRIVE;
        else                    phase = PH_SETTLE;
    end

    assign pull_en = (phase == PH_DRIVE);
    assign busy    = (phase != PH_IDLE);

    // R2
    start_drives_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> pull_en);
    // R3
    drive_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_en) |-> !$past(start));
    // R9
    settle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (pull_en && !start && cnt == LIMIT + CW'(1)) |=> (busy && !pull_en));
endmodule

// File: rtl/rst_hub_filter.sv
module rst_hub_filter #(
    parameter int unsigned VALID_CYC = 37,
    parameter int unsigned SPIKE_MAX = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    input  logic mask,
    output logic low_det
);
    localparam int FW = $clog2(VALID_CYC + 1);
    localparam logic [FW-1:0] TOP  = FW'(VALID_CYC);
    localparam logic [FW-1:0] DOWN = FW'(SPIKE_MAX);

    logic [FW-1:0] level;

    always_ff @(posedge clk) begin
        if (rst || mask) begin
            level <= '0;
        end else if (!pad_in) begin
            if (level != TOP) level <= level + FW'(1);
        end else begin
            if (level > DOWN) level <= level - DOWN;
            else              level <= '0;
        end
    end

    assign low_det = (level == TOP);

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= TOP);
    // R7
    det_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(low_det) |-> !$past(pad_in));
    // R9
    mask_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mask |=> !low_det);
endmodule

// File: rtl/rst_hub.sv
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int unsigned DRIVE_CYC  = 2500,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned VALID_CYC  = 37,
    parameter int unsigned SPIKE_MAX  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic por_req,
    input  logic iwdg_req,
    input  logic wwdg_req,
    input  logic dbg_req,
    input  logic illop_req,
    input  logic pad_in,
    output logic pad_pull_en,
    output logic sys_rst
);
    rst_src_t src;
    logic     req_any;
    logic     req_start;
    logic     busy;
    logic     ext_det;
    logic     sys_rst_q;

    assign src = '{por: por_req, iwdg: iwdg_req, wwdg: wwdg_req,
                   dbg: dbg_req, illop: illop_req};

    rst_hub_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .req_any   (req_any),
        .req_start (req_start)
    );

    rst_hub_stretch #(
        .DRIVE_CYC  (DRIVE_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .start   (req_start),
        .pull_en (pad_pull_en),
        .busy    (busy)
    );

    rst_hub_filter #(
        .VALID_CYC (VALID_CYC),
        .SPIKE_MAX (SPIKE_MAX)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .mask    (busy),
        .low_det (ext_det)
    );

    always_ff @(posedge clk) begin
        if (rst) sys_rst_q <= 1'b1;
        else     sys_rst_q <= req_any | busy | ext_det;
    end

    assign sys_rst = sys_rst_q;

    // R5
    request_holds_chk: assert property (@(posedge clk) disable iff (rst)
        req_any |=> sys_rst);
    // R5
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> sys_rst);
    // R9
    self_pull_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        pad_pull_en |=> !ext_det);
endmodule

// File: tb/rst_hub_bench.sv
module rst_hub_bench;
    localparam int S = 2500;
    localparam int T = 4;
    localparam int V = 37;
    localparam int D = 6;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] src_drv = '0;
    logic ext_lvl = 1'b1;
    logic pad_in;
    logic pad_pull_en;
    logic sys_rst;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign pad_in = ext_lvl & ~pad_pull_en;

    rst_hub #(.DRIVE_CYC(S), .SETTLE_CYC(T), .VALID_CYC(V), .SPIKE_MAX(D)) u_rst_hub (
        .clk         (clk),
        .rst         (rst),
        .por_req     (src_drv[0]),
        .iwdg_req    (src_drv[1]),
        .wwdg_req    (src_drv[2]),
        .dbg_req     (src_drv[3]),
        .illop_req   (src_drv[4]),
        .pad_in      (pad_in),
        .pad_pull_en (pad_pull_en),
        .sys_rst     (sys_rst)
    );

    // behavioural reference, updated on every rising edge
    int m_left = 0;
    int m_filt = 0;
    bit m_prev = 0;
    bit m_sys = 1;
    bit started = 0;
    bit any_now;
    int left_before;

    always @(posedge clk) begin
        any_now = |src_drv;
        started = 1;
        if (rst) begin
            m_left = 0; m_filt = 0; m_prev = 0; m_sys = 1;
        end else begin
            left_before = m_left;
            m_sys = any_now || (m_left != 0) || (m_filt == V);
            if (left_before != 0)  m_filt = 0;
            else if (!pad_in)      m_filt = (m_filt < V) ? m_filt + 1 : V;
            else                   m_filt = (m_filt > D) ? m_filt - D : 0;
            if (any_now && !m_prev) m_left = S + T;
            else if (m_left > 0)    m_left = m_left - 1;
            m_prev = any_now;
        end
    end

    // per-cycle comparison and run-length monitors
    int pull_run = 0, pull_last = 0, sys_run = 0, sys_last = 0;

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (sys_rst !== m_sys) begin
                fails++;
                $display("FAIL R5 model sys_rst act %0b exp %0b at %0t", sys_rst, m_sys, $time);
            end
            checks++;
            if (pad_pull_en !== (m_left > T)) begin
                fails++;
                $display("FAIL R3 model pad_pull_en act %0b exp %0b at %0t",
                         pad_pull_en, (m_left > T), $time);
            end
        end
        if (pad_pull_en === 1'b1) pull_run++;
        else if (pull_run != 0) begin pull_last = pull_run; pull_run = 0; end
        if (sys_rst === 1'b1 && !rst) sys_run++;
        else if (sys_run != 0) begin sys_last = sys_run; sys_run = 0; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic pulse_src(input int idx, input int len);
        @(negedge clk); #1 src_drv[idx] = 1'b1;
        repeat (len) @(negedge clk);
        #1 src_drv[idx] = 1'b0;
    endtask

    task automatic ext_low(input int len);
        @(negedge clk); #1 ext_lvl = 1'b0;
        repeat (len) @(negedge clk);
        #1 ext_lvl = 1'b1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic clear_runs();
        #2 pull_last = 0; sys_last = 0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check(sys_rst === 1'b1, "R1 sys_rst in reset", sys_rst, 1);
        check(pad_pull_en === 1'b0, "R1 pad_pull_en in reset", pad_pull_en, 0);
        #1 rst = 1'b0;
        @(negedge clk);
        check(sys_rst === 1'b0, "R1 sys_rst after reset", sys_rst, 0);
        settle(3);

        // R2, R3, R5: each source in turn, one-cycle pulse
        for (int k = 0; k < 5; k++) begin
            clear_runs();
            @(negedge clk); #1 src_drv[k] = 1'b1;
            @(negedge clk);
            check(pad_pull_en === 1'b1, "R2 pull after one-cycle request", pad_pull_en, 1);
            #1 src_drv[k] = 1'b0;
            settle(S + T + 10);
            check(pull_last == S, "R3 pull run length", pull_last, S);
            check(sys_last == S + T + 1, "R5 sys_rst run length", sys_last, S + T + 1);
        end

        // R4 restart during a stretch
        clear_runs();
        pulse_src(0, 1);
        repeat (999) @(negedge clk);
        pulse_src(3, 1);
        settle(S + T + 10);
        check(pull_last == 1001 + S, "R4 restarted pull run", pull_last, 1001 + S);

        // R10 request held past the stretch
        clear_runs();
        pulse_src(1, S + 300);
        settle(20);
        check(pull_last == S, "R10 held request pull run", pull_last, S);
        check(sys_last == S + 300, "R10 held request sys_rst run", sys_last, S + 300);

        // R6 low run one short of the threshold
        clear_runs();
        ext_low(V - 1);
        settle(50);
        check(sys_last == 0, "R6 short low ignored", sys_last, 0);

        // R7 exact threshold and long low
        clear_runs();
        ext_low(V);
        settle(50);
        check(sys_last == 1, "R7 threshold low run", sys_last, 1);
        clear_runs();
        ext_low(3 * V);
        settle(50);
        check(sys_last == 2 * V + 1, "R7 long low run", sys_last, 2 * V + 1);
        check(pull_last == 0, "R7 external low no pull", pull_last, 0);

        // R8 spike trains
        clear_runs();
        for (int p = 0; p < 200; p++) begin
            ext_low(D);
            @(negedge clk);
        end
        settle(20);
        check(sys_last == 0, "R8 max spike train rejected", sys_last, 0);
        clear_runs();
        for (int p = 0; p < 200; p++) begin
            ext_low(3);
            @(negedge clk);
        end
        settle(20);
        check(sys_last == 0, "R8 short spike train rejected", sys_last, 0);

        // R9 own pulse and an external low inside the masked window
        clear_runs();
        pulse_src(4, 1);
        repeat (99) @(negedge clk);
        ext_low(S - 99);
        settle(200);
        check(sys_last == S + T + 1, "R9 masked low sys_rst run", sys_last, S + T + 1);
        check(pull_last == S, "R9 masked low pull run", pull_last, S);
        check(sys_rst === 1'b0, "R9 no retrigger", sys_rst, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule